// File: doc/BRIEF.md
# Victim Write-Back Buffer with L1 Inclusion Race Handling

This block holds lines that an L2 cache has chosen as victims while their write-back to memory is in flight. The L2 keeps its contents a superset of a write-back L1, so each victim needs two things before it can leave. First, its data must be read out of the L2 data array. Second, the L1 must give up any copy it holds. Each slot records these two things as separate completion flags. When the L2 read is complete, the block sends an inclusion (subset-enforcement) request up to the L1. When both flags are set, the block offers the line to memory and frees the slot once memory accepts it.

The L1 may evict the same line on its own while the L2 victimization is still in progress. Its write-back carries the newest data, so that data replaces whatever the slot holds and is what goes to memory. If that write-back lands before the L2 array read finishes, the read completion finds the L1 flag already set. The block then clears the L1 flag, keeps the L1 data, and still issues the enforcement request. The L1 no longer holds the line, so it answers with a NACK, and the NACK sets the L1 flag again. A write-back that lands after the request was sent simply serves as the L1's answer. Neither ordering leaves a slot waiting forever.

Outgoing requests use valid/ready handshakes. A request that is not accepted stays pending in its slot, and pending slots are served lowest index first. A running count of accepted enforcement requests is kept. An error pulse reports a completion or a NACK that names a tag held by no slot.

Top module: `wb_victim_buf`

## Requirements
- R1: After reset no slot is in use: `enf_valid`, `mem_valid` and `err_o` are 0, `enf_count` is 0 and `alloc_ready` is 1.
- R2: An allocation is taken into the lowest-numbered free slot. `alloc_ready` is 0 while all NUM_ENTRIES slots are in use, and an allocation offered while it is 0 is dropped: its tag matches no slot afterwards.
- R3: A data-read completion for a held tag, with the L1 flag clear, stores the supplied L2 data and schedules an enforcement request for that tag. The memory write-back is not offered until the L1 path is also done.
- R4: `enf_valid` stays high until `enf_ready` is seen, and among pending slots the lowest index is offered first. `enf_count` rises by one for each accepted request.
- R5: An L1 write-back for a held tag replaces the slot's data and marks the L1 path done. The memory write-back then carries the L1 data.
- R6: A NACK for a held tag marks the L1 path done without touching the data. After a non-raced NACK, memory receives the L2 read data.
- R7: Race: if the data-read completion finds the L1 path already done, the L1 data is kept, the L1 flag is cleared and an enforcement request is still issued. Memory is offered the line only after the following NACK, and it carries the L1 data.
- R8: `mem_valid` is offered only for a slot with both flags set and no enforcement outstanding. It stays high until `mem_ready`, and the handshake frees the slot so that `alloc_ready` returns to 1.
- R9: `err_o` is high for exactly one cycle, the cycle after a data-read completion or a NACK whose tag matches no slot. An L1 write-back with no matching slot is ignored and raises no error.
- R10: When several slots are ready for memory, the lowest index is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a victim slot |
| alloc_tag | input | TAG_W | Tag of the victim line |
| alloc_ready | output | 1 | A free slot exists |
| rd_done_valid | input | 1 | L2 data-array read for a victim finished |
| rd_done_tag | input | TAG_W | Tag of the finished read |
| rd_done_data | input | DATA_W | Data read from the L2 array |
| l1wb_valid | input | 1 | Write-back arriving from L1 |
| l1wb_tag | input | TAG_W | Tag of the L1 write-back |
| l1wb_data | input | DATA_W | Data from L1 |
| nack_valid | input | 1 | L1 refused an enforcement request |
| nack_tag | input | TAG_W | Tag of the refused request |
| enf_valid | output | 1 | Enforcement request to L1 pending |
| enf_ready | input | 1 | L1 side accepts the request |
| enf_tag | output | TAG_W | Tag of the enforcement request |
| mem_valid | output | 1 | Write-back toward memory pending |
| mem_ready | input | 1 | Memory side accepts the write-back |
| mem_tag | output | TAG_W | Tag of the write-back |
| mem_data | output | DATA_W | Data of the write-back |
| err_o | output | 1 | One-cycle pulse: completion or NACK with no matching slot |
| enf_count | output | CNT_W | Number of accepted enforcement requests |

## Verification
The hardest case to reach from the ports is the early race. The L1 write-back has to reach a slot after allocation but before the array read reports completion, so the read completion then sees the L1 path already marked done. The bench holds the read completion back and injects the L1 write-back between allocation and completion. It then checks three things: the completion issues a request instead of freeing the line, memory stays idle until the NACK, and the data that leaves is the L1 copy. A further scenario fills every slot and releases completions and NACKs out of index order, which exercises the lowest-index selection on both outgoing channels.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef struct packed {
        logic valid;      // slot holds a victim
        logic data_done;  // L2 array read finished
        logic l1_done;    // L1 path finished
        logic enf_pend;   // enforcement request waiting to be sent
        logic enf_wait;   // enforcement sent, L1 answer outstanding
    } wbb_flags_t;

endpackage

// File: rtl/wbb_first_one.sv
module wbb_first_one #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found  = 1'b1;
                idx    = IDX_W'(i);
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wbb_tag_cam.sv
module wbb_tag_cam #(
    parameter int N     = 4,
    parameter int TAG_W = 16
) (
    input  logic [N-1:0]            live,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hit,
    output logic                    any_hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = live[g] && (tags[g] == key);
    end
    assign any_hit = |hit;
endmodule

// File: rtl/wb_victim_buf.sv
module wb_victim_buf
    import wbb_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int TAG_W       = 16,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic              alloc_ready,
    input  logic              rd_done_valid,
    input  logic [TAG_W-1:0]  rd_done_tag,
    input  logic [DATA_W-1:0] rd_done_data,
    input  logic              l1wb_valid,
    input  logic [TAG_W-1:0]  l1wb_tag,
    input  logic [DATA_W-1:0] l1wb_data,
    input  logic              nack_valid,
    input  logic [TAG_W-1:0]  nack_tag,
    output logic              enf_valid,
    input  logic              enf_ready,
    output logic [TAG_W-1:0]  enf_tag,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [TAG_W-1:0]  mem_tag,
    output logic [DATA_W-1:0] mem_data,
    output logic              err_o,
    output logic [CNT_W-1:0]  enf_count
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    typedef struct packed {
        wbb_flags_t [NUM_ENTRIES-1:0]              flg;
        logic       [NUM_ENTRIES-1:0][TAG_W-1:0]   tag;
        logic       [NUM_ENTRIES-1:0][DATA_W-1:0]  data;
        logic       [CNT_W-1:0]                    cnt;
        logic                                      err;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_ENTRIES-1:0] live_q, free_q, pend_q, done_q;
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_status
        assign live_q[g] = st_q.flg[g].valid;
        assign free_q[g] = !st_q.flg[g].valid;
        assign pend_q[g] = st_q.flg[g].valid && st_q.flg[g].enf_pend;
        assign done_q[g] = st_q.flg[g].valid && st_q.flg[g].data_done
                         && st_q.flg[g].l1_done && !st_q.flg[g].enf_pend
                         && !st_q.flg[g].enf_wait;
    end

    logic                   free_any, enf_any, mem_any;
    logic [IDX_W-1:0]       free_idx, enf_idx, mem_idx;
    logic [NUM_ENTRIES-1:0] free_oh, enf_oh, mem_oh;

    wbb_first_one #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_free (
        .req(free_q), .found(free_any), .idx(free_idx), .onehot(free_oh));
    wbb_first_one #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_enf (
        .req(pend_q), .found(enf_any), .idx(enf_idx), .onehot(enf_oh));
    wbb_first_one #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_mem (
        .req(done_q), .found(mem_any), .idx(mem_idx), .onehot(mem_oh));

    logic [NUM_ENTRIES-1:0] rd_hit, wb_hit, nk_hit;
    logic                   rd_any, wb_any, nk_any;

    wbb_tag_cam #(.N(NUM_ENTRIES), .TAG_W(TAG_W)) u_cam_rd (
        .live(live_q), .tags(st_q.tag), .key(rd_done_tag),
        .hit(rd_hit), .any_hit(rd_any));
    wbb_tag_cam #(.N(NUM_ENTRIES), .TAG_W(TAG_W)) u_cam_wb (
        .live(live_q), .tags(st_q.tag), .key(l1wb_tag),
        .hit(wb_hit), .any_hit(wb_any));
    wbb_tag_cam #(.N(NUM_ENTRIES), .TAG_W(TAG_W)) u_cam_nk (
        .live(live_q), .tags(st_q.tag), .key(nack_tag),
        .hit(nk_hit), .any_hit(nk_any));

    logic alloc_fire, enf_fire, mem_fire;
    assign alloc_fire = alloc_valid && free_any;
    assign enf_fire   = enf_any && enf_ready;
    assign mem_fire   = mem_any && mem_ready;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            // enforcement accepted: now waiting for the L1 answer
            if (enf_fire && enf_oh[i]) begin
                st_d.flg[i].enf_pend = 1'b0;
                st_d.flg[i].enf_wait = 1'b1;
            end
            // L1 write-back: newest data, L1 path done
            if (l1wb_valid && wb_hit[i]) begin
                st_d.data[i]         = l1wb_data;
                st_d.flg[i].l1_done  = 1'b1;
                st_d.flg[i].enf_wait = 1'b0;
            end
            // L1 refused the request: it no longer holds the line
            if (nack_valid && nk_hit[i]) begin
                st_d.flg[i].l1_done  = 1'b1;
                st_d.flg[i].enf_wait = 1'b0;
            end
            // L2 array read finished
            if (rd_done_valid && rd_hit[i]) begin
                st_d.flg[i].data_done = 1'b1;
                st_d.flg[i].enf_pend  = 1'b1;
                if (st_d.flg[i].l1_done) begin
                    // race: keep L1 data, re-open the L1 path
                    st_d.flg[i].l1_done = 1'b0;
                end else begin
                    st_d.data[i] = rd_done_data;
                end
            end
            // memory accepted the line: release the slot
            if (mem_fire && mem_oh[i]) begin
                st_d.flg[i] = '0;
            end
            if (alloc_fire && free_oh[i]) begin
                st_d.flg[i]       = '0;
                st_d.flg[i].valid = 1'b1;
                st_d.tag[i]       = alloc_tag;
                st_d.data[i]      = '0;
            end
        end
        if (enf_fire) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.err = (rd_done_valid && !rd_any) || (nack_valid && !nk_any);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_ready = free_any;
    assign enf_valid   = enf_any;
    assign enf_tag     = st_q.tag[enf_idx];
    assign mem_valid   = mem_any;
    assign mem_tag     = st_q.tag[mem_idx];
    assign mem_data    = st_q.data[mem_idx];
    assign err_o       = st_q.err;
    assign enf_count   = st_q.cnt;

    logic unused_wb_any;
    assign unused_wb_any = wb_any;
endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
    parameter int TAG_W  = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_done_valid,
    input logic             nack_valid,
    input logic             enf_valid,
    input logic             enf_ready,
    input logic [TAG_W-1:0] enf_tag,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [TAG_W-1:0] mem_tag,
    input logic             err_o,
    input logic [CNT_W-1:0] enf_count
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (enf_count == '0 && !err_o && !enf_valid && !mem_valid));

    // R4
    a_r4_enf_held: assert property (@(posedge clk) disable iff (!rst_n)
        (enf_valid && !enf_ready) |=> enf_valid);

    // R4
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enf_valid && enf_ready) |=> (enf_count == $past(enf_count) + CNT_W'(1)));

    // R4
    a_r4_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(enf_valid && enf_ready) |=> $stable(enf_count));

    // R8
    a_r8_mem_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> mem_valid);

    // R8
    a_r8_no_mem_while_enf: assert property (@(posedge clk) disable iff (!rst_n)
        (enf_valid && mem_valid) |-> (enf_tag != mem_tag));

    // R9
    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(rd_done_valid || nack_valid));
endmodule

bind wb_victim_buf wbb_checker #(.TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_wbb_chk (
    .clk(clk), .rst_n(rst_n), .rd_done_valid(rd_done_valid), .nack_valid(nack_valid),
    .enf_valid(enf_valid), .enf_ready(enf_ready), .enf_tag(enf_tag),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_tag(mem_tag),
    .err_o(err_o), .enf_count(enf_count));

// File: tb/test_wb_victim_buf.sv
module test_wb_victim_buf;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W  = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              alloc_valid, rd_done_valid, l1wb_valid, nack_valid;
    logic [TAG_W-1:0]  alloc_tag, rd_done_tag, l1wb_tag, nack_tag;
    logic [DATA_W-1:0] rd_done_data, l1wb_data;
    logic              enf_ready, mem_ready;
    logic              alloc_ready, enf_valid, mem_valid, err_o;
    logic [TAG_W-1:0]  enf_tag, mem_tag;
    logic [DATA_W-1:0] mem_data;
    logic [CNT_W-1:0]  enf_count;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wb_victim_buf #(.NUM_ENTRIES(4), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_wb_victim_buf (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_ready(alloc_ready),
        .rd_done_valid(rd_done_valid), .rd_done_tag(rd_done_tag), .rd_done_data(rd_done_data),
        .l1wb_valid(l1wb_valid), .l1wb_tag(l1wb_tag), .l1wb_data(l1wb_data),
        .nack_valid(nack_valid), .nack_tag(nack_tag),
        .enf_valid(enf_valid), .enf_ready(enf_ready), .enf_tag(enf_tag),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_tag(mem_tag), .mem_data(mem_data),
        .err_o(err_o), .enf_count(enf_count));

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [TAG_W-1:0] t);
        alloc_valid = 1'b1; alloc_tag = t; cyc(); alloc_valid = 1'b0;
    endtask

    task automatic do_rd(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
        rd_done_valid = 1'b1; rd_done_tag = t; rd_done_data = d; cyc(); rd_done_valid = 1'b0;
    endtask

    task automatic do_l1wb(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
        l1wb_valid = 1'b1; l1wb_tag = t; l1wb_data = d; cyc(); l1wb_valid = 1'b0;
    endtask

    task automatic do_nack(input logic [TAG_W-1:0] t);
        nack_valid = 1'b1; nack_tag = t; cyc(); nack_valid = 1'b0;
    endtask

    task automatic take_enf(input string req, input logic [TAG_W-1:0] t);
        chk(req, "enf_valid before accept", 64'(enf_valid), 64'(1));
        chk(req, "enf_tag", 64'(enf_tag), 64'(t));
        enf_ready = 1'b1; cyc(); enf_ready = 1'b0;
        exp_cnt++;
        chk("R4", "enf_count", 64'(enf_count), 64'(exp_cnt));
    endtask

    task automatic take_mem(input string req, input logic [TAG_W-1:0] t,
                            input logic [DATA_W-1:0] d);
        chk(req, "mem_valid before accept", 64'(mem_valid), 64'(1));
        chk(req, "mem_tag", 64'(mem_tag), 64'(t));
        chk(req, "mem_data", 64'(mem_data), 64'(d));
        mem_ready = 1'b1; cyc(); mem_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "enf_valid", 64'(enf_valid), 64'(0));
        chk("R1", "mem_valid", 64'(mem_valid), 64'(0));
        chk("R1", "err_o", 64'(err_o), 64'(0));
        chk("R1", "enf_count", 64'(enf_count), 64'(0));
        chk("R1", "alloc_ready", 64'(alloc_ready), 64'(1));
    endtask

    task automatic t_nack_path();
        do_alloc(16'h00A1);
        chk("R3", "no enf before read", 64'(enf_valid), 64'(0));
        do_rd(16'h00A1, 32'hD1D1_0001);
        chk("R3", "mem waits for L1", 64'(mem_valid), 64'(0));
        take_enf("R3", 16'h00A1);
        chk("R8", "mem waits for L1 answer", 64'(mem_valid), 64'(0));
        do_nack(16'h00A1);
        chk("R6", "nack gives no error", 64'(err_o), 64'(0));
        take_mem("R6", 16'h00A1, 32'hD1D1_0001);
        chk("R8", "slot freed", 64'(mem_valid), 64'(0));
    endtask

    task automatic t_l1_answer();
        do_alloc(16'h00B2);
        do_rd(16'h00B2, 32'h2222_0002);
        take_enf("R3", 16'h00B2);
        do_l1wb(16'h00B2, 32'h3333_0003);
        take_mem("R5", 16'h00B2, 32'h3333_0003);
    endtask

    task automatic t_race();
        do_alloc(16'h00C3);
        do_l1wb(16'h00C3, 32'h4444_0004);
        chk("R7", "no mem before read", 64'(mem_valid), 64'(0));
        chk("R7", "no enf before read", 64'(enf_valid), 64'(0));
        do_rd(16'h00C3, 32'h5555_0005);
        chk("R7", "race still issues enf", 64'(enf_valid), 64'(1));
        chk("R7", "race does not complete", 64'(mem_valid), 64'(0));
        take_enf("R7", 16'h00C3);
        repeat (2) cyc();
        chk("R7", "mem waits for nack", 64'(mem_valid), 64'(0));
        do_nack(16'h00C3);
        take_mem("R7", 16'h00C3, 32'h4444_0004);
    endtask

    task automatic t_order();
        for (int k = 0; k < 4; k++) do_alloc(16'h0010 + 16'(k));
        chk("R2", "alloc_ready when full", 64'(alloc_ready), 64'(0));
        do_alloc(16'h0099);
        do_rd(16'h0099, 32'h0);
        chk("R2", "dropped alloc holds no slot", 64'(err_o), 64'(1));
        do_rd(16'h0012, 32'h1200_0000);
        chk("R9", "err one cycle", 64'(err_o), 64'(0));
        do_rd(16'h0011, 32'h1100_0000);
        chk("R4", "lowest pending first", 64'(enf_tag), 64'(16'h0011));
        repeat (3) cyc();
        chk("R4", "request held while not ready", 64'(enf_valid), 64'(1));
        take_enf("R4", 16'h0011);
        take_enf("R4", 16'h0012);
        do_nack(16'h0012);
        do_nack(16'h0011);
        take_mem("R10", 16'h0011, 32'h1100_0000);
        chk("R8", "freed slot restores alloc_ready", 64'(alloc_ready), 64'(1));
        take_mem("R10", 16'h0012, 32'h1200_0000);
        do_rd(16'h0013, 32'h1300_0000);
        do_rd(16'h0010, 32'h1000_0000);
        take_enf("R2", 16'h0010);
        take_enf("R2", 16'h0013);
        do_nack(16'h0013);
        do_nack(16'h0010);
        take_mem("R2", 16'h0010, 32'h1000_0000);
        take_mem("R2", 16'h0013, 32'h1300_0000);
        chk("R8", "all slots drained", 64'(mem_valid), 64'(0));
    endtask

    task automatic t_errors();
        do_nack(16'h0EEE);
        chk("R9", "nack without slot", 64'(err_o), 64'(1));
        cyc();
        chk("R9", "pulse ends", 64'(err_o), 64'(0));
        do_l1wb(16'h0FFF, 32'hDEAD_BEEF);
        chk("R9", "stray L1 wb no error", 64'(err_o), 64'(0));
        chk("R9", "stray L1 wb no mem", 64'(mem_valid), 64'(0));
        chk("R9", "stray L1 wb no enf", 64'(enf_valid), 64'(0));
    endtask

    initial begin
        rst_n = 1'b0;
        alloc_valid = 0; rd_done_valid = 0; l1wb_valid = 0; nack_valid = 0;
        alloc_tag = '0; rd_done_tag = '0; l1wb_tag = '0; nack_tag = '0;
        rd_done_data = '0; l1wb_data = '0; enf_ready = 0; mem_ready = 0;
        repeat (3) cyc();
        rst_n = 1'b1;
        t_reset();
        t_nack_path();
        t_l1_answer();
        t_race();
        t_order();
        t_errors();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule